// File: doc/BRIEF.md
# Dual-Clock FIFO Pointer Reset Selector

This block produces the two reset signals that clear the write pointer and the read pointer of a FIFO whose two ports run on unrelated clocks. Each side has its own reset input and its own clock. A 2-bit source mode per side chooses how that side's pointer reset is formed. The options are a plain pass-through of the side's own reset, an immediate assert with a synchronized release, fully sampled assert and release, or the opposite side's reset brought across through this side's synchronizer. A 2-bit depth code per side sets the synchronizer length to between two and five flops.

Each side also reports a ready flag and a sticky error flag. The ready flag tells the user when FIFO access may resume, which is a fixed number of own-clock edges after the reset source goes low. The error flag records a reset pulse that was held too briefly for the chosen depth. Both sides share one implementation. An active-low power-on reset, asserted asynchronously and released separately in each clock domain, puts both sides into their reset state.

Top module: `fifo_rst_sel`

## Requirements
- R1: Each side's synchronizer length is N = depth code + 2 (code 2'b00 gives 2 stages, 2'b01 gives 3, 2'b10 gives 4, 2'b11 gives 5), and the two sides are set independently.
- R2: In mode 2'b00 the pointer reset follows the side's own reset input with no clock edge in between, on both rise and fall.
- R3: In mode 2'b01 the pointer reset rises with the side's own reset input without waiting for a clock edge. It falls on the Nth own-clock rising edge that samples the input low.
- R4: In mode 2'b10 the pointer reset rises on the Nth own-clock edge that samples the own reset input high, and falls on the Nth edge that samples it low.
- R5: In mode 2'b11 the pointer reset follows the opposite side's reset input with the same N-edge latency as R4, and the side's own reset input has no effect on any of its outputs.
- R6: Ready goes low on the first own-clock edge that samples the source high in mode 2'b00, and on the second such edge in the other modes. It goes high on the (N+3)th edge that samples the source low.
- R7: If a reset pulse was sampled high on fewer than N+3 own-clock edges, the error flag sets within two edges of its end. The flag stays set through later pulses until power-on reset, and a pulse of exactly N+3 samples leaves it clear.
- R8: While the power-on reset is low, ready and error are low, and the pointer reset is high in every mode except 2'b00. After release, with the reset inputs low, the side becomes ready with its pointer reset low.
- R9: Unless a side is in mode 2'b11, the opposite side's reset input has no effect on its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| wr_rst | input | 1 | Write-side reset request, active high |
| rd_rst | input | 1 | Read-side reset request, active high |
| wr_mode | input | 2 | Write-pointer reset source mode |
| rd_mode | input | 2 | Read-pointer reset source mode |
| wr_depth | input | 2 | Write-side synchronizer length code |
| rd_depth | input | 2 | Read-side synchronizer length code |
| wr_ptr_rst | output | 1 | Write-pointer clear, active high |
| rd_ptr_rst | output | 1 | Read-pointer clear, active high |
| wr_ready | output | 1 | Write side may be accessed |
| rd_ready | output | 1 | Read side may be accessed |
| wr_err | output | 1 | Sticky: write-side source pulse too short |
| rd_err | output | 1 | Sticky: read-side source pulse too short |

## Verification
A synchronizer stage stuck or mis-tapped shifts the pointer reset edge by whole clocks, so the edge-by-edge comparison flags it on the very edge where the release should occur. A wrong load value or decrement in the recovery counter moves the rising edge of ready away from edge N+3 after the source falls, which is visible within at most eight edges. A faulty pulse-length counter either raises the error flag after a pulse of exactly N+3 samples or leaves it clear after a pulse of N+2 samples, and this shows two edges after the pulse ends. A wrong source selection shows as a pointer reset that reacts to the reset input of the wrong side.

// File: rtl/frs_pkg.sv
`timescale 1ns/1ps
package frs_pkg;

  // Source mode of one pointer reset
  typedef enum logic [1:0] {
    RST_DIRECT   = 2'b00,  // own input, used as is
    RST_ASYNC_IN = 2'b01,  // own input, immediate assert, chain release
    RST_SAMPLED  = 2'b10,  // own input through the chain both ways
    RST_PEER     = 2'b11   // opposite side's input through the chain
  } rst_src_e;

endpackage

// File: rtl/frs_por_sync.sv
`timescale 1ns/1ps
// Power-on reset conditioner: asynchronous assert, release after STAGES clocks.
module frs_por_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/frs_side.sv
`timescale 1ns/1ps
// One pointer-reset path: source select, synchronizer chain, recovery
// counter and short-pulse detector. Both sides of the FIFO use this module.
module frs_side
  import frs_pkg::*;
#(
  parameter int unsigned MIN_STAGES = 2,
  parameter int unsigned MAX_STAGES = 5,
  parameter int unsigned GUARD      = 3,
  parameter int unsigned DEPTH_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               own_rst,
  input  logic               peer_rst,
  input  logic [1:0]         mode,
  input  logic [DEPTH_W-1:0] depth,
  output logic               ptr_rst,
  output logic               ready,
  output logic               err
);

  localparam int unsigned CNT_W = $clog2(MAX_STAGES + GUARD + 1);
  localparam int unsigned IDX_W = $clog2(MAX_STAGES);
  localparam logic [CNT_W-1:0] HOLD_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(MAX_STAGES + GUARD);

  rst_src_e              src_mode;
  logic                  src;
  logic                  trig;
  logic                  tap;
  logic [CNT_W-1:0]      n_stages;
  logic [CNT_W-1:0]      win;
  logic [CNT_W-1:0]      load_val;
  logic [IDX_W-1:0]      tap_idx;
  logic [MAX_STAGES-1:0] chain_q;
  logic [MAX_STAGES-1:0] chain_d;
  logic [CNT_W-1:0]      cnt_q;
  logic [CNT_W-1:0]      cnt_d;
  logic [CNT_W-1:0]      hold_q;
  logic [CNT_W-1:0]      hold_d;
  logic                  err_q;
  logic                  err_d;

  assign src_mode = rst_src_e'(mode);

  // Depth decode and source selection
  always_comb begin
    n_stages = CNT_W'(depth) + CNT_W'(MIN_STAGES);
    win      = n_stages + CNT_W'(GUARD);
    tap_idx  = IDX_W'(n_stages - CNT_W'(1));
    src      = (src_mode == RST_PEER) ? peer_rst : own_rst;
  end

  // Synchronizer chain next state; the chain powers up holding reset
  for (genvar g = 0; g < MAX_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign chain_d[g] = src;
    end else begin : g_body
      assign chain_d[g] = chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign tap = chain_q[tap_idx];

  // Pointer reset shaping and the event that drives the recovery counter.
  // Chain modes see the source one edge later, so they load one less.
  always_comb begin
    unique case (src_mode)
      RST_DIRECT: begin
        ptr_rst  = src;
        trig     = src;
        load_val = win;
      end
      RST_ASYNC_IN: begin
        ptr_rst  = src | tap;
        trig     = chain_q[0];
        load_val = win - CNT_W'(1);
      end
      default: begin
        ptr_rst  = tap;
        trig     = chain_q[0];
        load_val = win - CNT_W'(1);
      end
    endcase
  end

  // Recovery counter and pulse-length detector next state
  always_comb begin
    if (trig)                cnt_d = load_val;
    else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
    else                     cnt_d = cnt_q;

    if (!trig)                   hold_d = '0;
    else if (hold_q != HOLD_MAX) hold_d = hold_q + CNT_W'(1);
    else                         hold_d = hold_q;

    err_d = err_q | (!trig && (hold_q != '0) && (hold_q < win));
  end

  // A saturated hold count at power-on counts as a long pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_INIT;
      hold_q <= HOLD_MAX;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      err_q  <= err_d;
    end
  end

  assign ready = (cnt_q == '0);
  assign err   = err_q;

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_INIT);

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !ready);

  // R6
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !$past(trig));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R4
  chain_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_mode == RST_SAMPLED || src_mode == RST_PEER) && ready) |-> !ptr_rst);

endmodule

// File: rtl/fifo_rst_sel.sv
`timescale 1ns/1ps
// Pointer reset selector for a dual-clock FIFO: one path per clock domain.
module fifo_rst_sel
  import frs_pkg::*;
#(
  parameter int unsigned MIN_STAGES = 2,
  parameter int unsigned MAX_STAGES = 5,
  parameter int unsigned GUARD      = 3,
  parameter int unsigned POR_STAGES = 2,
  parameter int unsigned DEPTH_W    = $clog2(MAX_STAGES - MIN_STAGES + 1)
) (
  input  logic               sys_rst_n,
  input  logic               wr_clk,
  input  logic               rd_clk,
  input  logic               wr_rst,
  input  logic               rd_rst,
  input  logic [1:0]         wr_mode,
  input  logic [1:0]         rd_mode,
  input  logic [DEPTH_W-1:0] wr_depth,
  input  logic [DEPTH_W-1:0] rd_depth,
  output logic               wr_ptr_rst,
  output logic               rd_ptr_rst,
  output logic               wr_ready,
  output logic               rd_ready,
  output logic               wr_err,
  output logic               rd_err
);

  logic wr_por_n;
  logic rd_por_n;

  frs_por_sync #(.STAGES(POR_STAGES)) u_wr_por (
    .clk    (wr_clk),
    .arst_n (sys_rst_n),
    .rst_n  (wr_por_n)
  );

  frs_por_sync #(.STAGES(POR_STAGES)) u_rd_por (
    .clk    (rd_clk),
    .arst_n (sys_rst_n),
    .rst_n  (rd_por_n)
  );

  frs_side #(
    .MIN_STAGES (MIN_STAGES),
    .MAX_STAGES (MAX_STAGES),
    .GUARD      (GUARD),
    .DEPTH_W    (DEPTH_W)
  ) u_wr_side (
    .clk      (wr_clk),
    .rst_n    (wr_por_n),
    .own_rst  (wr_rst),
    .peer_rst (rd_rst),
    .mode     (wr_mode),
    .depth    (wr_depth),
    .ptr_rst  (wr_ptr_rst),
    .ready    (wr_ready),
    .err      (wr_err)
  );

  frs_side #(
    .MIN_STAGES (MIN_STAGES),
    .MAX_STAGES (MAX_STAGES),
    .GUARD      (GUARD),
    .DEPTH_W    (DEPTH_W)
  ) u_rd_side (
    .clk      (rd_clk),
    .rst_n    (rd_por_n),
    .own_rst  (rd_rst),
    .peer_rst (wr_rst),
    .mode     (rd_mode),
    .depth    (rd_depth),
    .ptr_rst  (rd_ptr_rst),
    .ready    (rd_ready),
    .err      (rd_err)
  );

endmodule

// File: tb/tb_fifo_rst_sel.sv
`timescale 1ns/1ps
module tb_fifo_rst_sel;

  logic       sys_rst_n, wr_clk, rd_clk, wr_rst, rd_rst;
  logic [1:0] wr_mode, rd_mode, wr_depth, rd_depth;
  logic       wr_ptr_rst, rd_ptr_rst, wr_ready, rd_ready, wr_err, rd_err;
  int         checks = 0;
  int         fails  = 0;

  fifo_rst_sel dut (
    .sys_rst_n (sys_rst_n), .wr_clk (wr_clk), .rd_clk (rd_clk),
    .wr_rst (wr_rst), .rd_rst (rd_rst),
    .wr_mode (wr_mode), .rd_mode (rd_mode),
    .wr_depth (wr_depth), .rd_depth (rd_depth),
    .wr_ptr_rst (wr_ptr_rst), .rd_ptr_rst (rd_ptr_rst),
    .wr_ready (wr_ready), .rd_ready (rd_ready),
    .wr_err (wr_err), .rd_err (rd_err)
  );

  // 200 MHz write clock, unrelated 7 ns read clock
  initial begin wr_clk = 1'b0; forever #2.5 wr_clk = ~wr_clk; end
  initial begin rd_clk = 1'b0; forever #3.5 rd_clk = ~rd_clk; end

  // side (0 write, 1 read), mode, depth code, short pulse,
  // expected: assert latency, release latency, ready latency, error
  typedef struct packed {
    logic       side;
    logic [1:0] mode;
    logic [1:0] depth;
    logic       short_p;
    logic [2:0] alat;
    logic [2:0] rlat;
    logic [3:0] rdy;
    logic       err;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b1, 2'd0, 2'd0, 1'b0, 3'd0, 3'd0, 4'd5, 1'b0},
    '{1'b0, 2'd0, 2'd1, 1'b1, 3'd0, 3'd0, 4'd6, 1'b1},
    '{1'b1, 2'd0, 2'd2, 1'b0, 3'd0, 3'd0, 4'd7, 1'b0},
    '{1'b0, 2'd0, 2'd3, 1'b0, 3'd0, 3'd0, 4'd8, 1'b0},
    '{1'b0, 2'd1, 2'd0, 1'b1, 3'd0, 3'd2, 4'd5, 1'b1},
    '{1'b1, 2'd1, 2'd1, 1'b0, 3'd0, 3'd3, 4'd6, 1'b0},
    '{1'b0, 2'd1, 2'd2, 1'b0, 3'd0, 3'd4, 4'd7, 1'b0},
    '{1'b1, 2'd1, 2'd3, 1'b1, 3'd0, 3'd5, 4'd8, 1'b1},
    '{1'b1, 2'd2, 2'd0, 1'b0, 3'd2, 3'd2, 4'd5, 1'b0},
    '{1'b0, 2'd2, 2'd1, 1'b0, 3'd3, 3'd3, 4'd6, 1'b0},
    '{1'b1, 2'd2, 2'd2, 1'b1, 3'd4, 3'd4, 4'd7, 1'b1},
    '{1'b0, 2'd2, 2'd3, 1'b0, 3'd5, 3'd5, 4'd8, 1'b0},
    '{1'b1, 2'd3, 2'd0, 1'b0, 3'd2, 3'd2, 4'd5, 1'b0},
    '{1'b0, 2'd3, 2'd1, 1'b1, 3'd3, 3'd3, 4'd6, 1'b1},
    '{1'b1, 2'd3, 2'd2, 1'b0, 3'd4, 3'd4, 4'd7, 1'b0},
    '{1'b0, 2'd3, 2'd3, 1'b0, 3'd5, 3'd5, 4'd8, 1'b0}
  };

  function automatic logic ptr_of(input logic s);
    return s ? rd_ptr_rst : wr_ptr_rst;
  endfunction
  function automatic logic ready_of(input logic s);
    return s ? rd_ready : wr_ready;
  endfunction
  function automatic logic err_of(input logic s);
    return s ? rd_err : wr_err;
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic hold_por(input logic [1:0] wm, input logic [1:0] wd,
                          input logic [1:0] rm, input logic [1:0] rdd);
    sys_rst_n = 1'b0;
    wr_rst    = 1'b0;
    rd_rst    = 1'b0;
    wr_mode   = wm;
    wr_depth  = wd;
    rd_mode   = rm;
    rd_depth  = rdd;
    #30;
  endtask

  task automatic release_por();
    sys_rst_n = 1'b1;
    repeat (20) @(posedge rd_clk);
    #1;
  endtask

  // Wait for the next rising edge of a side's clock, then sample after it
  task automatic side_edge(input logic s);
    if (s) @(posedge rd_clk);
    else   @(posedge wr_clk);
    #1;
  endtask

  // Drive the reset input feeding a side, on the falling edge of its clock
  task automatic drive_src(input logic s, input logic [1:0] m, input logic v);
    if (s ^ (m == 2'b11)) begin @(negedge rd_clk); rd_rst = v; end
    else                  begin @(negedge wr_clk); wr_rst = v; end
  endtask

  task automatic run_vec(input vec_t v);
    int    n;
    int    h;
    string req;
    n = int'(v.depth) + 2;  // R1: chain length from the depth code
    h = v.short_p ? n + 1 : n + 4;
    case (v.mode)
      2'd0:    req = "R1/R2";
      2'd1:    req = "R1/R3";
      2'd2:    req = "R1/R4";
      default: req = "R1/R5";
    endcase
    if (v.side) hold_por(2'b00, 2'b00, v.mode, v.depth);
    else        hold_por(v.mode, v.depth, 2'b00, 2'b00);
    chk(err_of(v.side), 1'b0, "R8", "error during power-on reset");
    chk(ready_of(v.side), 1'b0, "R8", "ready during power-on reset");
    chk(ptr_of(v.side), v.mode != 2'b00, "R8", "pointer reset during power-on reset");
    release_por();
    chk(ready_of(v.side), 1'b1, "R8", "ready after power-on");
    chk(ptr_of(v.side), 1'b0, "R8", "pointer reset after power-on");
    chk(err_of(v.side), 1'b0, "R8", "error after power-on");

    drive_src(v.side, v.mode, 1'b1);
    #0.2;
    chk(ptr_of(v.side), v.alat == 3'd0, req, "pointer reset before first edge");
    chk(ready_of(v.side), 1'b1, "R6", "ready before first edge");
    for (int k = 1; k <= h; k++) begin
      side_edge(v.side);
      chk(ptr_of(v.side), k >= int'(v.alat), req, "pointer reset while source high");
      chk(ready_of(v.side), k < ((v.mode == 2'b00) ? 1 : 2), "R6", "ready while source high");
    end

    drive_src(v.side, v.mode, 1'b0);
    #0.2;
    chk(ptr_of(v.side), v.rlat != 3'd0, req, "pointer reset right after source low");
    for (int j = 1; j <= n + 4; j++) begin
      side_edge(v.side);
      chk(ptr_of(v.side), j < int'(v.rlat), req, "pointer reset after source low");
      chk(ready_of(v.side), j >= int'(v.rdy), "R6", "ready recovery");
    end
    chk(err_of(v.side), v.err, "R7", "short pulse flag");
  endtask

  // Read-side pulse on its own input, h sampled edges, then settle
  task automatic pulse_rd(input int h);
    @(negedge rd_clk); rd_rst = 1'b1;
    repeat (h) side_edge(1'b1);
    @(negedge rd_clk); rd_rst = 1'b0;
    repeat (12) side_edge(1'b1);
  endtask

  initial begin : watchdog
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    sys_rst_n = 1'b0;
    wr_rst = 1'b0; rd_rst = 1'b0;
    wr_mode = 2'b00; rd_mode = 2'b00; wr_depth = 2'b00; rd_depth = 2'b00;

    // Table walk: every mode at every depth
    for (int i = 0; i < 16; i++) run_vec(VECS[i]);

    // R5: own input ignored in peer mode
    hold_por(2'b00, 2'b00, 2'b11, 2'b00);
    release_por();
    @(negedge rd_clk); rd_rst = 1'b1;
    for (int k = 0; k < 10; k++) begin
      side_edge(1'b1);
      chk(rd_ptr_rst, 1'b0, "R5", "read pointer reset with own input high");
      chk(rd_ready, 1'b1, "R5", "read ready with own input high");
    end
    @(negedge rd_clk); rd_rst = 1'b0;
    repeat (4) side_edge(1'b1);
    chk(rd_err, 1'b0, "R5", "read error after ignored pulse");

    // R9: peer input ignored outside peer mode
    hold_por(2'b00, 2'b00, 2'b10, 2'b01);
    release_por();
    @(negedge wr_clk); wr_rst = 1'b1;
    for (int k = 0; k < 10; k++) begin
      side_edge(1'b1);
      chk(rd_ptr_rst, 1'b0, "R9", "read pointer reset with write input high");
      chk(rd_ready, 1'b1, "R9", "read ready with write input high");
    end
    @(negedge wr_clk); wr_rst = 1'b0;
    repeat (4) side_edge(1'b1);
    chk(rd_err, 1'b0, "R9", "read error after write pulse");

    // R7: exact window boundary, depth code 1 gives a window of 6
    hold_por(2'b00, 2'b00, 2'b00, 2'b01);
    release_por();
    pulse_rd(6);
    chk(rd_err, 1'b0, "R7", "pulse of exactly N+3 samples");
    hold_por(2'b00, 2'b00, 2'b00, 2'b01);
    release_por();
    pulse_rd(5);
    chk(rd_err, 1'b1, "R7", "pulse of N+2 samples");
    pulse_rd(10);
    chk(rd_err, 1'b1, "R7", "error stays set after long pulse");
    hold_por(2'b00, 2'b00, 2'b00, 2'b01);
    chk(rd_err, 1'b0, "R8", "power-on reset clears error");
    release_por();
    chk(rd_err, 1'b0, "R8", "error clear after power-on");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule